// File: doc/BRIEF.md
# Peripheral Domain Access Guard

This block decides, for every bus transaction aimed at a peripheral, whether the requesting master may perform it. Each bus master is first mapped to one of four isolation domains through a master table. The chosen domain then selects a 2-bit permission field inside a per-peripheral policy word. Both lookups are combinational, so the allow decision, the requester's domain and the peripheral's semaphore flag all appear in the same cycle as the request.

Software fills both tables through a small synchronous write port. The same port reads back any entry combinationally, and it reports the domain of the master that is driving the configuration access. Every entry carries a sticky lock bit. Once the lock is set, later writes to that entry are silently dropped until the next reset. Indices beyond the configured table sizes address nothing.

Top module: `dom_access_guard`

## Requirements
- R1: After reset every master entry reads back 0, which means domain 0 and unlocked.
- R2: After reset every peripheral entry reads back 32'h0000_00FF, which means read and write for all four domains, semaphore clear and lock clear.
- R3: A write with `cfg_tbl`=0 to an unlocked master entry stores `cfg_wdata[1:0]` as the domain and `cfg_wdata[31]` as the lock. Readback shows the lock in bit 31 and the domain in bits 1:0, with every other bit 0.
- R4: A write with `cfg_tbl`=1 to an unlocked peripheral entry stores `cfg_wdata[7:0]` as the permissions, `cfg_wdata[30]` as the semaphore flag and `cfg_wdata[31]` as the lock. Readback shows exactly those bits, with every other bit 0.
- R5: A write to a locked entry in either table has no effect, and the lock stays set until reset.
- R6: The permission field for domain d sits at bits [2d+1:2d] and is encoded as 0 none, 1 write only, 2 read only, 3 read and write. `chk_allow` is 1 when field bit 0 is set for a write (`chk_write`=1), or when field bit 1 is set for a read (`chk_write`=0). The result appears in the same cycle as the request.
- R7: `chk_dom` shows the domain of `chk_master` in the same cycle.
- R8: `cfg_dom` shows the domain of `cfg_master`.
- R9: `chk_sema` shows the semaphore flag of `chk_periph`.
- R10: When a master index is at or above NM, or a peripheral index is at or above NP, the following hold: the access is denied, the reported domain and semaphore are 0, readback is 0, and writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl | input | 1 | Table select: 0 master table, 1 peripheral table |
| cfg_idx | input | IW | Entry index for write and readback |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Readback of the selected entry |
| cfg_master | input | MW | Master performing the configuration access |
| cfg_dom | output | 2 | Domain of `cfg_master` |
| chk_master | input | MW | Requesting master |
| chk_periph | input | PW | Target peripheral |
| chk_write | input | 1 | 1 for write, 0 for read |
| chk_allow | output | 1 | Access permitted |
| chk_dom | output | 2 | Domain of the requesting master |
| chk_sema | output | 1 | Semaphore flag of the target peripheral |

## Verification
The hardest situation to reach is a locked entry that keeps its old value while unlocked neighbours change, followed by a reset that must free it. The bench locks a subset of entries in both tables and then floods every index, including those past the table ends, with fresh random values. After each round it sweeps every combination of master, peripheral and direction against a model in the bench. A reset in the middle of the run is then checked for unlocked, default contents.

// File: rtl/dom_access_guard.sv
`timescale 1ns/1ps
module dom_access_guard #(
  parameter int NM = 6,
  parameter int NP = 5,
  localparam int MW = (NM > 1) ? $clog2(NM) : 1,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1,
  localparam int IW = (MW > PW) ? MW : PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_tbl,
  input  logic [IW-1:0] cfg_idx,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [MW-1:0] cfg_master,
  output logic [1:0]    cfg_dom,
  input  logic [MW-1:0] chk_master,
  input  logic [PW-1:0] chk_periph,
  input  logic          chk_write,
  output logic          chk_allow,
  output logic [1:0]    chk_dom,
  output logic          chk_sema
);
  logic [1:0] m_dom  [NM];
  logic       m_lck  [NM];
  logic [7:0] p_perm [NP];
  logic       p_sema [NP];
  logic       p_lck  [NP];

  wire unused_wdata = ^cfg_wdata[29:8];

  for (genvar i = 0; i < NM; i++) begin : g_mst
    wire wr = cfg_we && !cfg_tbl && (cfg_idx == IW'(i)) && !m_lck[i];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        m_dom[i] <= 2'd0;
        m_lck[i] <= 1'b0;
      end else if (wr) begin
        m_dom[i] <= cfg_wdata[1:0];
        m_lck[i] <= cfg_wdata[31];
      end
  end

  for (genvar j = 0; j < NP; j++) begin : g_per
    wire wr = cfg_we && cfg_tbl && (cfg_idx == IW'(j)) && !p_lck[j];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        p_perm[j] <= 8'hFF;
        p_sema[j] <= 1'b0;
        p_lck[j]  <= 1'b0;
      end else if (wr) begin
        p_perm[j] <= cfg_wdata[7:0];
        p_sema[j] <= cfg_wdata[30];
        p_lck[j]  <= cfg_wdata[31];
      end
  end

  always_comb begin
    cfg_rdata = 32'd0;
    if (!cfg_tbl) begin
      for (int i = 0; i < NM; i++)
        if (cfg_idx == IW'(i)) cfg_rdata = {m_lck[i], 29'd0, m_dom[i]};
    end else begin
      for (int j = 0; j < NP; j++)
        if (cfg_idx == IW'(j)) cfg_rdata = {p_lck[j], p_sema[j], 22'd0, p_perm[j]};
    end
  end

  logic       hit_m, hit_p;
  logic [7:0] perm;

  always_comb begin
    hit_m = 1'b0; chk_dom = 2'd0; cfg_dom = 2'd0;
    for (int i = 0; i < NM; i++) begin
      if (chk_master == MW'(i)) begin hit_m = 1'b1; chk_dom = m_dom[i]; end
      if (cfg_master == MW'(i)) cfg_dom = m_dom[i];
    end
  end

  always_comb begin
    hit_p = 1'b0; perm = 8'd0; chk_sema = 1'b0;
    for (int j = 0; j < NP; j++)
      if (chk_periph == PW'(j)) begin
        hit_p = 1'b1; perm = p_perm[j]; chk_sema = p_sema[j];
      end
  end

  assign chk_allow = hit_m && hit_p && perm[{chk_dom, !chk_write}];
endmodule

// File: rtl/dom_access_guard_chk.sv
`timescale 1ns/1ps
module dom_access_guard_chk #(
  parameter int NM = 6,
  parameter int NP = 5,
  parameter int MW = 3,
  parameter int PW = 3,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          cfg_tbl,
  input logic [IW-1:0] cfg_idx,
  input logic [31:0]   cfg_wdata,
  input logic [31:0]   cfg_rdata,
  input logic [MW-1:0] chk_master,
  input logic [PW-1:0] chk_periph,
  input logic          chk_allow,
  input logic [1:0]    chk_dom,
  input logic          chk_sema,
  input logic [1:0]    m_dom  [NM],
  input logic          m_lck  [NM],
  input logic [7:0]    p_perm [NP],
  input logic          p_lck  [NP]
);
  for (genvar i = 0; i < NM; i++) begin : g_m
    a_r5_master_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      m_lck[i] |=> m_lck[i] && $stable(m_dom[i]));
    a_r3_master_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_tbl && cfg_idx == IW'(i) && !m_lck[i])
        |=> (m_dom[i] == $past(cfg_wdata[1:0])) && (m_lck[i] == $past(cfg_wdata[31])));
  end

  for (genvar j = 0; j < NP; j++) begin : g_p
    a_r5_periph_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      p_lck[j] |=> p_lck[j] && $stable(p_perm[j]));
  end

  a_r10_range_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(chk_master) >= NM || int'(chk_periph) >= NP) |-> !chk_allow);
  a_r7_range_dom_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(chk_master) >= NM) |-> chk_dom == 2'd0);
  a_r9_range_sema_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(chk_periph) >= NP) |-> !chk_sema);
  a_r10_range_readback_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((!cfg_tbl && int'(cfg_idx) >= NM) || (cfg_tbl && int'(cfg_idx) >= NP)) |-> cfg_rdata == 32'd0);
endmodule

bind dom_access_guard dom_access_guard_chk #(.NM(NM), .NP(NP), .MW(MW), .PW(PW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_idx(cfg_idx),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .chk_master(chk_master),
  .chk_periph(chk_periph), .chk_allow(chk_allow), .chk_dom(chk_dom), .chk_sema(chk_sema),
  .m_dom(m_dom), .m_lck(m_lck), .p_perm(p_perm), .p_lck(p_lck)
);

// File: tb/sim_dom_access_guard.sv
`timescale 1ns/1ps
module sim_dom_access_guard;
  localparam int NM = 6, NP = 5, MW = 3, PW = 3, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_tbl = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [MW-1:0] cfg_master = '0, chk_master = '0;
  logic [1:0] cfg_dom, chk_dom;
  logic [PW-1:0] chk_periph = '0;
  logic chk_write = 1'b0, chk_allow, chk_sema;

  always #10 clk = ~clk;

  dom_access_guard #(.NM(NM), .NP(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_master(cfg_master), .cfg_dom(cfg_dom),
    .chk_master(chk_master), .chk_periph(chk_periph), .chk_write(chk_write),
    .chk_allow(chk_allow), .chk_dom(chk_dom), .chk_sema(chk_sema));

  int total = 0, bad = 0;
  bit finished = 0;

  logic [1:0] e_mdom [NM];
  logic       e_mlck [NM];
  logic [7:0] e_perm [NP];
  logic       e_sema [NP];
  logic       e_plck [NP];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NM; i++) begin e_mdom[i] = 2'd0; e_mlck[i] = 1'b0; end
    for (int j = 0; j < NP; j++) begin e_perm[j] = 8'hFF; e_sema[j] = 1'b0; e_plck[j] = 1'b0; end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    model_reset();
  endtask

  task automatic wr(input logic tbl, input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tbl = tbl; cfg_idx = IW'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!tbl && idx < NM && !e_mlck[idx]) begin e_mdom[idx] = d[1:0]; e_mlck[idx] = d[31]; end
    if (tbl && idx < NP && !e_plck[idx]) begin
      e_perm[idx] = d[7:0]; e_sema[idx] = d[30]; e_plck[idx] = d[31];
    end
  endtask

  task automatic sweep(input string tag);
    for (int m = 0; m < (1 << MW); m++)
      for (int p = 0; p < (1 << PW); p++)
        for (int w = 0; w < 2; w++) begin
          logic ea; logic [1:0] ed; logic es;
          @(negedge clk);
          chk_master = MW'(m); chk_periph = PW'(p); chk_write = w[0];
          #5;
          ed = (m < NM) ? e_mdom[m] : 2'd0;
          es = (p < NP) ? e_sema[p] : 1'b0;
          ea = (m < NM && p < NP) ? e_perm[p][2*ed + (w ? 0 : 1)] : 1'b0;
          chk({tag, " R6/R10 allow"}, {31'd0, chk_allow}, {31'd0, ea});
          chk({tag, " R7 dom"}, {30'd0, chk_dom}, {30'd0, ed});
          chk({tag, " R9 sema"}, {31'd0, chk_sema}, {31'd0, es});
        end
    for (int m = 0; m < (1 << MW); m++) begin
      @(negedge clk); cfg_master = MW'(m); #5;
      chk({tag, " R8 cfg_dom"}, {30'd0, cfg_dom}, {30'd0, (m < NM) ? e_mdom[m] : 2'd0});
    end
    for (int i = 0; i < (1 << IW); i++) begin
      @(negedge clk); cfg_tbl = 1'b0; cfg_idx = IW'(i); #5;
      chk({tag, " R1/R3 master readback"}, cfg_rdata,
          (i < NM) ? {e_mlck[i], 29'd0, e_mdom[i]} : 32'd0);
      cfg_tbl = 1'b1; #2;
      chk({tag, " R2/R4 periph readback"}, cfg_rdata,
          (i < NP) ? {e_plck[i], e_sema[i], 22'd0, e_perm[i]} : 32'd0);
    end
  endtask

  initial begin
    model_reset();
    do_reset();
    sweep("reset R1 R2");

    for (int i = 0; i < (1 << IW); i++) begin
      wr(1'b0, i, {1'b0, 29'h0ABCDE0 ^ 29'(i), 2'(i + 1)});
      wr(1'b1, i, {1'b0, i[0], 22'h2AAAAA, 8'(8'h1B + 8'(i * 37))});
    end
    sweep("write R3 R4");

    wr(1'b0, 1, 32'h8000_0002);
    wr(1'b1, 2, 32'hC000_0036);
    wr(1'b1, 4, 32'h8000_0009);
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < (1 << IW); i++) begin
        wr(1'b0, i, $urandom() & 32'h7FFF_FFFF);
        wr(1'b1, i, $urandom() & 32'h7FFF_FFFF);
      end
      sweep("locked R5");
    end

    wr(1'b0, 4, 32'h8000_0003);
    wr(1'b0, 4, 32'h0000_0001);
    sweep("relock R5");

    do_reset();
    sweep("after reset R5 R1 R2");
    wr(1'b1, 3, 32'h0000_0000);
    wr(1'b1, 0, 32'h4000_00E4);
    wr(1'b0, 0, 32'h0000_0003);
    wr(1'b0, 5, 32'h0000_0002);
    sweep("patterns R6 R9");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule